// File: doc/BRIEF.md
# Unaligned Burst Read Splitter

This block sits between a DMA engine and a bus master. It takes one burst read request, made of a byte address, a byte count and a read command, and turns it into an ordered list of bus read transactions. Each transaction carries a word-aligned address, a word count, byte enables for its first and last word, and keep masks that tell the data path which returned bytes belong to the request.

A software-visible optimize bit selects the policy. When the bit is clear, or the command is an I/O read, the request is split at word boundaries. The split gives a partial-word leading transaction, a run of whole words, and a partial-word trailing transaction, each with exact byte enables and each independent of the others. When the bit is set and the command is one of the three memory read kinds, the whole span is read as one transaction with all byte enables asserted. The keep masks then mark the requested bytes in the first and last word, so that the data path can discard the rest. The mode and the request are both captured when the request is accepted. Bus timing and data buffering belong to the neighbouring blocks.

Top module: `burst_rd_splitter`

## Requirements
- R1: The optimize bit reads back as 0 after reset. One cycle after a write strobe it reads back the value written.
- R2: In split mode, a request produces its transactions in the order leading, middle, trailing. The leading and trailing transactions are one word long, and their byte enables equal exactly the requested bytes of that word. Byte enable bit i selects the byte whose address modulo the word size is i. The middle transaction covers every whole requested word and has all enables set.
- R3: A segment that would hold no bytes is not issued. An aligned start gives no leading transaction, and an end on a word boundary gives no trailing transaction.
- R4: A request that lies inside one word produces exactly one transaction, whose byte enables cover only the requested bytes.
- R5: When the optimize bit is 1 and the command is memory read (1), memory read line (2) or memory read multiple (3), the request produces exactly one transaction. That transaction has the aligned address of the first word, a word count equal to the number of words touched, and all byte enables set.
- R6: In optimize mode, keep-first marks the requested bytes of the first word and keep-last marks those of the last word. In split mode, each keep mask equals the matching byte-enable mask.
- R7: An I/O read (command 0) is always split as in R2, whatever the value of the optimize bit.
- R8: txn_last is 1 on the final transaction of a request and 0 on every earlier one.
- R9: A request with a byte count of zero is accepted and produces no transaction.
- R10: req_ready is 1 only when no transaction is pending. While txn_valid is 1 and txn_ready is 0, the presented transaction holds steady. The mode in force when a request is accepted governs all of that request's transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the optimize bit |
| cfg_wr_opt | input | 1 | Value to write to the optimize bit |
| cfg_opt_rd | output | 1 | Current optimize bit |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Splitter idle, request accepted this cycle |
| req_addr | input | AW | Byte start address |
| req_len | input | LW | Byte count |
| req_cmd | input | 2 | 0 I/O read, 1 memory read, 2 read line, 3 read multiple |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Transaction taken by the bus master |
| txn_addr | output | AW | Word-aligned transaction address |
| txn_words | output | LW | Number of words in the transaction |
| txn_cmd | output | 2 | Command of the originating request |
| txn_be_first | output | BPW | Bus byte enables for the first word |
| txn_be_last | output | BPW | Bus byte enables for the last word |
| txn_keep_first | output | BPW | Requested bytes in the first returned word |
| txn_keep_last | output | BPW | Requested bytes in the last returned word |
| txn_last | output | 1 | Final transaction of the request |

## Verification
The bench builds the block with an 8-bit address, a 6-bit byte count and 4-byte words. With these sizes it can sweep every start lane over three words, every byte count from 0 to 18, all four commands and both modes. That sweep reaches single-word requests, aligned and unaligned ends, and middle runs of zero to four words. The expected transaction list is rebuilt in the bench by grouping per-word byte masks. A separate stalled run holds txn_ready low and flips the mode while the block is busy, which shows that the held transaction stays put and the captured mode keeps governing the request.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int NSEG = 3;
  localparam int SEG_LEAD = 0;
  localparam int SEG_MID  = 1;
  localparam int SEG_TAIL = 2;

  typedef enum logic [1:0] {
    CMD_IO_RD   = 2'd0,
    CMD_MEM_RD  = 2'd1,
    CMD_MEM_RDL = 2'd2,
    CMD_MEM_RDM = 2'd3
  } rd_cmd_e;
endpackage

// File: rtl/bsplit_opt_reg.sv
module bsplit_opt_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic opt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     opt_q <= 1'b0;
    else if (wr_en) opt_q <= wr_data;
  end

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (opt_q == $past(wr_data)));
  a_r1_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(opt_q));
endmodule

// File: rtl/bsplit_plan.sv
module bsplit_plan #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int BPW = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [LW-1:0]  len,
  input  logic [1:0]     cmd,
  input  logic           opt,
  output logic [bsplit_pkg::NSEG-1:0] seg_vld,
  output logic [AW-1:0]  seg_addr  [bsplit_pkg::NSEG],
  output logic [LW-1:0]  seg_words [bsplit_pkg::NSEG],
  output logic [BPW-1:0] seg_bef   [bsplit_pkg::NSEG],
  output logic [BPW-1:0] seg_bel   [bsplit_pkg::NSEG],
  output logic [BPW-1:0] seg_kf    [bsplit_pkg::NSEG],
  output logic [BPW-1:0] seg_kl    [bsplit_pkg::NSEG]
);
  import bsplit_pkg::*;

  localparam int OW = $clog2(BPW);
  localparam logic [BPW-1:0] ALL_ON = {BPW{1'b1}};

  // Byte lanes lo .. lo+n-1 of one word.
  function automatic logic [BPW-1:0] lane_mask(input int lo, input int n);
    logic [BPW-1:0] m;
    for (int b = 0; b < BPW; b++) m[b] = (b >= lo) && (b < lo + n);
    return m;
  endfunction

  // Bytes before the first word boundary, capped by the count.
  function automatic int lead_bytes(input int off, input int n);
    if (off == 0) return 0;
    return (n < BPW - off) ? n : BPW - off;
  endfunction

  // Words touched by n bytes starting at lane off.
  function automatic int words_spanned(input int off, input int n);
    return (off + n + BPW - 1) / BPW;
  endfunction

  int off_i, len_i, lead_i, rest_i, mid_i, tail_i, span_i, end_lane;
  logic          collapse;
  logic [AW-1:0] base, mid_base, tail_base;
  logic [BPW-1:0] kf_all, kl_all;

  always_comb begin
    off_i    = int'(addr[OW-1:0]);
    len_i    = int'(len);
    collapse = opt && (rd_cmd_e'(cmd) != CMD_IO_RD) && (len_i != 0);
    lead_i   = lead_bytes(off_i, len_i);
    rest_i   = len_i - lead_i;
    mid_i    = rest_i / BPW;
    tail_i   = rest_i % BPW;
    span_i   = words_spanned(off_i, len_i);
    end_lane = (off_i + len_i - 1) % BPW;
    base      = {addr[AW-1:OW], {OW{1'b0}}};
    mid_base  = base + ((lead_i != 0) ? AW'(BPW) : '0);
    tail_base = mid_base + AW'(mid_i * BPW);
    kf_all   = lane_mask(off_i, len_i);
    kl_all   = (span_i == 1) ? kf_all : lane_mask(0, end_lane + 1);
  end

  always_comb begin
    if (collapse) begin
      seg_vld             = '0;
      seg_vld[SEG_LEAD]   = 1'b1;
      seg_addr[SEG_LEAD]  = base;
      seg_words[SEG_LEAD] = LW'(span_i);
      seg_bef[SEG_LEAD]   = ALL_ON;
      seg_bel[SEG_LEAD]   = ALL_ON;
      seg_kf[SEG_LEAD]    = kf_all;
      seg_kl[SEG_LEAD]    = kl_all;
    end else begin
      seg_vld[SEG_LEAD]   = (lead_i != 0);
      seg_addr[SEG_LEAD]  = base;
      seg_words[SEG_LEAD] = LW'(1);
      seg_bef[SEG_LEAD]   = lane_mask(off_i, lead_i);
      seg_bel[SEG_LEAD]   = lane_mask(off_i, lead_i);
      seg_kf[SEG_LEAD]    = lane_mask(off_i, lead_i);
      seg_kl[SEG_LEAD]    = lane_mask(off_i, lead_i);
      seg_vld[SEG_MID]    = (mid_i != 0);
      seg_vld[SEG_TAIL]   = (tail_i != 0);
    end
    seg_addr[SEG_MID]   = mid_base;
    seg_words[SEG_MID]  = LW'(mid_i);
    seg_bef[SEG_MID]    = ALL_ON;
    seg_bel[SEG_MID]    = ALL_ON;
    seg_kf[SEG_MID]     = ALL_ON;
    seg_kl[SEG_MID]     = ALL_ON;
    seg_addr[SEG_TAIL]  = tail_base;
    seg_words[SEG_TAIL] = LW'(1);
    seg_bef[SEG_TAIL]   = lane_mask(0, tail_i);
    seg_bel[SEG_TAIL]   = lane_mask(0, tail_i);
    seg_kf[SEG_TAIL]    = lane_mask(0, tail_i);
    seg_kl[SEG_TAIL]    = lane_mask(0, tail_i);
  end
endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int BPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_cmd,
  input  logic [bsplit_pkg::NSEG-1:0] seg_vld,
  input  logic [AW-1:0]  seg_addr  [bsplit_pkg::NSEG],
  input  logic [LW-1:0]  seg_words [bsplit_pkg::NSEG],
  input  logic [BPW-1:0] seg_bef   [bsplit_pkg::NSEG],
  input  logic [BPW-1:0] seg_bel   [bsplit_pkg::NSEG],
  input  logic [BPW-1:0] seg_kf    [bsplit_pkg::NSEG],
  input  logic [BPW-1:0] seg_kl    [bsplit_pkg::NSEG],
  output logic           txn_valid,
  input  logic           txn_ready,
  output logic [AW-1:0]  txn_addr,
  output logic [LW-1:0]  txn_words,
  output logic [1:0]     txn_cmd,
  output logic [BPW-1:0] txn_be_first,
  output logic [BPW-1:0] txn_be_last,
  output logic [BPW-1:0] txn_keep_first,
  output logic [BPW-1:0] txn_keep_last,
  output logic           txn_last
);
  import bsplit_pkg::*;

  localparam int SW = $clog2(NSEG);

  logic [NSEG-1:0] pend_q, sel_hot;
  logic [SW-1:0]   sel_idx;
  logic [1:0]      cmd_q;
  logic [AW-1:0]   addr_q  [NSEG];
  logic [LW-1:0]   words_q [NSEG];
  logic [BPW-1:0]  bef_q   [NSEG];
  logic [BPW-1:0]  bel_q   [NSEG];
  logic [BPW-1:0]  kf_q    [NSEG];
  logic [BPW-1:0]  kl_q    [NSEG];

  logic busy, req_fire, txn_fire;
  assign busy     = |pend_q;
  assign req_fire = req_valid && !busy;
  assign txn_fire = txn_valid && txn_ready;

  // Lowest pending segment goes first: lead, then middle, then tail.
  always_comb begin
    sel_idx = '0;
    for (int i = NSEG - 1; i >= 0; i--)
      if (pend_q[i]) sel_idx = SW'(i);
  end
  assign sel_hot = pend_q & (~pend_q + NSEG'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cmd_q  <= '0;
      for (int i = 0; i < NSEG; i++) begin
        addr_q[i] <= '0; words_q[i] <= '0;
        bef_q[i]  <= '0; bel_q[i]   <= '0;
        kf_q[i]   <= '0; kl_q[i]    <= '0;
      end
    end else if (req_fire) begin
      pend_q <= seg_vld;
      cmd_q  <= req_cmd;
      for (int i = 0; i < NSEG; i++) begin
        addr_q[i] <= seg_addr[i]; words_q[i] <= seg_words[i];
        bef_q[i]  <= seg_bef[i];  bel_q[i]   <= seg_bel[i];
        kf_q[i]   <= seg_kf[i];   kl_q[i]    <= seg_kl[i];
      end
    end else if (txn_fire) begin
      pend_q <= pend_q & ~sel_hot;
    end
  end

  assign req_ready      = !busy;
  assign txn_valid      = busy;
  assign txn_addr       = addr_q[sel_idx];
  assign txn_words      = words_q[sel_idx];
  assign txn_cmd        = cmd_q;
  assign txn_be_first   = bef_q[sel_idx];
  assign txn_be_last    = bel_q[sel_idx];
  assign txn_keep_first = kf_q[sel_idx];
  assign txn_keep_last  = kl_q[sel_idx];
  assign txn_last       = ((pend_q & ~sel_hot) == '0);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) &&
      $stable(txn_words) && $stable(txn_be_first) && $stable(txn_keep_last)));
  a_r9_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && (seg_vld == '0)) |=> !txn_valid);
  a_r8_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && txn_last) |=> !txn_valid);
  a_r8_not_last_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && !txn_last) |=> txn_valid);
  a_r3_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_hot));
endmodule

// File: rtl/burst_rd_splitter.sv
module burst_rd_splitter #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int BPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic           cfg_wr_opt,
  output logic           cfg_opt_rd,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [LW-1:0]  req_len,
  input  logic [1:0]     req_cmd,
  output logic           txn_valid,
  input  logic           txn_ready,
  output logic [AW-1:0]  txn_addr,
  output logic [LW-1:0]  txn_words,
  output logic [1:0]     txn_cmd,
  output logic [BPW-1:0] txn_be_first,
  output logic [BPW-1:0] txn_be_last,
  output logic [BPW-1:0] txn_keep_first,
  output logic [BPW-1:0] txn_keep_last,
  output logic           txn_last
);
  import bsplit_pkg::*;

  localparam logic [BPW-1:0] ALL_ON = {BPW{1'b1}};
  localparam int OW = $clog2(BPW);

  logic            opt_q;
  logic [NSEG-1:0] seg_vld;
  logic [AW-1:0]   seg_addr  [NSEG];
  logic [LW-1:0]   seg_words [NSEG];
  logic [BPW-1:0]  seg_bef   [NSEG];
  logic [BPW-1:0]  seg_bel   [NSEG];
  logic [BPW-1:0]  seg_kf    [NSEG];
  logic [BPW-1:0]  seg_kl    [NSEG];

  bsplit_opt_reg u_opt (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_opt), .opt_q(opt_q)
  );
  assign cfg_opt_rd = opt_q;

  bsplit_plan #(.AW(AW), .LW(LW), .BPW(BPW)) u_plan (
    .addr(req_addr), .len(req_len), .cmd(req_cmd), .opt(opt_q),
    .seg_vld(seg_vld), .seg_addr(seg_addr), .seg_words(seg_words),
    .seg_bef(seg_bef), .seg_bel(seg_bel), .seg_kf(seg_kf), .seg_kl(seg_kl)
  );

  bsplit_seq #(.AW(AW), .LW(LW), .BPW(BPW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .seg_vld(seg_vld), .seg_addr(seg_addr),
    .seg_words(seg_words), .seg_bef(seg_bef), .seg_bel(seg_bel),
    .seg_kf(seg_kf), .seg_kl(seg_kl),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
    .txn_words(txn_words), .txn_cmd(txn_cmd), .txn_be_first(txn_be_first),
    .txn_be_last(txn_be_last), .txn_keep_first(txn_keep_first),
    .txn_keep_last(txn_keep_last), .txn_last(txn_last)
  );

  a_r6_keep_within_be: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (((txn_keep_first & ~txn_be_first) == '0) &&
                   ((txn_keep_last & ~txn_be_last) == '0)));
  a_r7_io_exact_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_cmd == CMD_IO_RD) |->
      (txn_keep_first == txn_be_first && txn_keep_last == txn_be_last));
  a_r2_partial_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_be_first != ALL_ON) |-> (txn_words == LW'(1)));
  a_r3_no_empty_txn: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_words != '0 && txn_keep_first != '0 && txn_keep_last != '0));
  a_r5_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_addr[OW-1:0] == '0));
endmodule

// File: tb/sim_burst_rd_splitter.sv
`timescale 1ns/1ps
module sim_burst_rd_splitter;
  localparam int AW = 8, LW = 6, BPW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, cfg_wr_opt = 0, cfg_opt_rd;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [1:0] req_cmd = 0;
  logic txn_valid, txn_ready = 1, txn_last;
  logic [AW-1:0] txn_addr;
  logic [LW-1:0] txn_words;
  logic [1:0] txn_cmd;
  logic [BPW-1:0] txn_be_first, txn_be_last, txn_keep_first, txn_keep_last;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_rd_splitter #(.AW(AW), .LW(LW), .BPW(BPW)) u0 (.*);

  // Expected transaction list
  int n_exp;
  int e_addr[3], e_words[3], e_bf[3], e_bl[3], e_kf[3], e_kl[3];
  bit e_full[3];

  function automatic int wmask(int w, int a, int n);
    int m = 0;
    for (int b = 0; b < BPW; b++)
      if (w * BPW + b >= a && w * BPW + b < a + n) m |= (1 << b);
    return m;
  endfunction

  task automatic build_exp(int a, int n, int cmd, int opt);
    int fw, lw, m;
    n_exp = 0;
    if (n == 0) return;
    fw = a / BPW; lw = (a + n - 1) / BPW;
    if (opt != 0 && cmd != 0) begin
      n_exp = 1; e_addr[0] = fw * BPW; e_words[0] = lw - fw + 1;
      e_bf[0] = 15; e_bl[0] = 15; e_kf[0] = wmask(fw, a, n); e_kl[0] = wmask(lw, a, n);
      return;
    end
    for (int w = fw; w <= lw; w++) begin
      m = wmask(w, a, n);
      if (m == 15 && n_exp > 0 && e_full[n_exp-1]) e_words[n_exp-1]++;
      else begin
        e_addr[n_exp] = w * BPW; e_words[n_exp] = 1; e_full[n_exp] = (m == 15);
        e_bf[n_exp] = m; e_bl[n_exp] = m; e_kf[n_exp] = m; e_kl[n_exp] = m;
        n_exp++;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_txn(int k, int cmd, string tag);
    chk(txn_valid === 1'b1, tag, "txn_valid", int'(txn_valid), 1);
    chk(int'(txn_addr) == e_addr[k], tag, "addr", int'(txn_addr), e_addr[k]);
    chk(int'(txn_words) == e_words[k], tag, "words", int'(txn_words), e_words[k]);
    chk(int'(txn_be_first) == e_bf[k] && int'(txn_be_last) == e_bl[k], tag, "be first/last",
        int'({txn_be_first, txn_be_last}), (e_bf[k] << 4) | e_bl[k]);
    chk(int'(txn_keep_first) == e_kf[k] && int'(txn_keep_last) == e_kl[k], "R6", "keep first/last",
        int'({txn_keep_first, txn_keep_last}), (e_kf[k] << 4) | e_kl[k]);
    chk(txn_last == (k == n_exp - 1), "R8", "txn_last", int'(txn_last), int'(k == n_exp - 1));
    chk(int'(txn_cmd) == cmd, tag, "cmd", int'(txn_cmd), cmd);
  endtask

  task automatic run_req(int a, int n, int cmd, int opt, int stall);
    string tag;
    build_exp(a, n, cmd, opt);
    if (n == 0) tag = "R9";
    else if (opt != 0 && cmd != 0) tag = "R5";
    else if (cmd == 0) tag = "R7";
    else if (a % BPW + n <= BPW) tag = "R4";
    else tag = "R2";
    @(negedge clk); cfg_wr_en = 1; cfg_wr_opt = opt[0];
    @(negedge clk); cfg_wr_en = 0;
    chk(cfg_opt_rd == opt[0], "R1", "opt readback", int'(cfg_opt_rd), opt);
    chk(req_ready === 1'b1, "R10", "ready when idle", int'(req_ready), 1);
    req_valid = 1; req_addr = AW'(a); req_len = LW'(n); req_cmd = 2'(cmd);
    if (stall > 0) txn_ready = 0;
    @(negedge clk); req_valid = 0;
    if (stall > 0) begin
      for (int s = 0; s < stall; s++) begin
        cmp_txn(0, cmd, "R10");
        chk(req_ready === 1'b0, "R10", "not ready while busy", int'(req_ready), 0);
        cfg_wr_en = 1; cfg_wr_opt = ~opt[0];
        @(negedge clk); cfg_wr_en = 0;
      end
      txn_ready = 1;
    end
    for (int k = 0; k < n_exp; k++) begin
      cmp_txn(k, cmd, tag);
      @(negedge clk);
    end
    chk(txn_valid === 1'b0, (n == 0) ? "R9" : "R3", "no extra txn", int'(txn_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_opt_rd === 1'b0, "R1", "opt after reset", int'(cfg_opt_rd), 0);
    chk(txn_valid === 1'b0, "R10", "no txn after reset", int'(txn_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    // R3 spot checks: aligned start, word-boundary end
    run_req(4, 8, 1, 0, 0);
    chk(n_exp == 1, "R3", "aligned request count", n_exp, 1);
    run_req(5, 7, 1, 0, 0);
    chk(n_exp == 2, "R3", "end on boundary count", n_exp, 2);
    // R10: stall while mode flips, captured split mode must persist
    run_req(1, 10, 1, 0, 3);
    run_req(2, 9, 2, 1, 2);
    // R2 R4 R5 R6 R7 R8 R9 exhaustive sweep
    for (int opt = 0; opt < 2; opt++)
      for (int cmd = 0; cmd < 4; cmd++)
        for (int a = 0; a < 12; a++)
          for (int n = 0; n <= 18; n++)
            run_req(a, n, cmd, opt, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule